// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block drives a multiplexed analog-to-digital converter through a fixed scan of its input channels. For each conversion it points the analog multiplexer at a channel, lets the selection settle for one cycle, then fires a one-cycle start-of-conversion pulse. When the converter reports end of conversion, the sample is written to a buffer. The end-of-conversion strobe comes from the converter's own clock domain, so it is synchronized first. The sample is stored in the slot of the channel it was converted from, so each channel keeps a fixed position in memory.

Samples go into two ping-pong buffers, one sample word per channel in each. When the last channel of a pass has been written, a one-cycle scan-complete pulse marks the full buffer and filling moves on to the other buffer. In free-run mode the passes repeat without stopping. In one-shot mode the block makes one pass and then waits for a new start. A soft reset returns the block to channel 0, buffer 0 and idle, and drops any strobe still in flight.

The controller is a four-state machine:
- `ST_IDLE` goes to `ST_SETTLE` on start.
- `ST_SETTLE` goes to `ST_LAUNCH` unconditionally.
- `ST_LAUNCH` goes to `ST_WAIT` unconditionally.
- `ST_WAIT` leaves on a synchronized end-of-conversion event. It goes to `ST_SETTLE` if the pass is not finished or free-run is set, and otherwise to `ST_IDLE`.
- From every state, soft reset goes to `ST_IDLE`.

Top module: `adc_scan_seq`

## Requirements
- R1: Each rising edge of `eoc_async` seen while waiting for a conversion produces exactly one one-cycle `wr_en`. The write comes after a two-flop synchronizer and rising-edge detection. The number of writes equals the number of end-of-conversion strobes.
- R2: Conversions are started on channels 0, 1, 2, 3 in that order, repeating. `mux_sel` advances by one, wrapping after 3, on every accepted write.
- R3: A write stores the sample in the slot of the channel that was on `mux_sel` when that conversion's `soc` was issued. `wr_addr` is the byte address `(buf_idx*4 + channel)*2`. `wr_data` is the 12-bit sample zero-extended to 16 bits.
- R4: `buf_idx` is 0 after reset and toggles after each write of channel 3. Every write lands in the region of the current `buf_idx`.
- R5: `scan_done` is a one-cycle pulse that is high exactly in the cycle of the channel-3 write.
- R6: `soc` is high for one cycle only. `mux_sel` has held its value for at least the cycle before `soc` and during `soc`.
- R7: With `free_run` low, a start produces exactly one pass of four conversions. After that no `soc` is issued, and `mux_sel` is back at 0.
- R8: With `free_run` high, passes follow one another without a new start. A start pulse while a scan is running has no effect.
- R9: Asserting `soft_rst` returns `mux_sel` and `buf_idx` to 0 and the block to idle. An end-of-conversion strobe in flight at that moment produces no write.
- R10: An end-of-conversion strobe while the block is idle produces no write.
- R11: After `rst_n` is released, `soc`, `wr_en` and `scan_done` are low, and `mux_sel` and `buf_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous soft reset: channel 0, buffer 0, idle, strobe dropped |
| start | input | 1 | One-cycle request to begin scanning |
| free_run | input | 1 | 1: repeat passes; 0: stop after one pass |
| eoc_async | input | 1 | End-of-conversion strobe from the converter clock domain |
| smp_data | input | 12 | Converted sample, valid while the strobe is seen |
| soc | output | 1 | Start-of-conversion pulse |
| mux_sel | output | 2 | Analog multiplexer channel select |
| wr_addr | output | 4 | Buffer byte address of the sample slot |
| wr_data | output | 16 | Sample word written to the buffer |
| wr_en | output | 1 | Buffer write strobe |
| buf_idx | output | 1 | Ping-pong buffer currently being filled |
| scan_done | output | 1 | Pulse when a buffer holds a full pass |

## Verification
The hardest situation to reach is a soft reset that lands while a strobe is partway through the synchronizer. The strobe must then vanish without a write, even though the raw input is still high after the reset. The bench turns off its converter model and drives the strobe by hand. It raises the strobe one cycle before a one-cycle soft reset and keeps it high across the reset. It then checks that no write appears, that channel and buffer are back at 0, and that the next pass starts cleanly at slot 0. The tagging fault, where a sample lands in the following channel's slot, shows up because each random sample's address is compared with the channel recorded by the converter model at its own start pulse.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LAUNCH = 2'd2,
        ST_WAIT   = 2'd3
    } scan_state_e;

endpackage

// File: rtl/scan_eoc_sync.sv
module scan_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic eoc_async,
    output logic eoc_evt
);

    // stg[0..STAGES-1] form the synchronizer, stg[STAGES] holds the previous level
    logic [STAGES:0] stg;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                stg[i] <= 1'b0;
            else if (soft_rst)
                stg[i] <= 1'b0;
            else if (i == 0)
                stg[i] <= eoc_async;
            else
                stg[i] <= stg[(i == 0) ? 0 : i - 1];
        end
    end

    assign eoc_evt = stg[STAGES-1] & ~stg[STAGES];

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_evt |=> !eoc_evt);  // R1

endmodule

// File: rtl/scan_slot_map.sv
module scan_slot_map #(
    parameter int NUM_CH = 4,
    parameter int SMP_W  = 12,
    parameter int WORD_W = 16,
    parameter int CH_W   = 2,
    parameter int ADDR_W = 4
) (
    input  logic              buf_sel,
    input  logic [CH_W-1:0]   ch,
    input  logic [SMP_W-1:0]  smp,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [WORD_W-1:0] slot_word
);

    localparam int BYTES = WORD_W / 8;

    assign slot_addr = ADDR_W'((int'(buf_sel) * NUM_CH + int'(ch)) * BYTES);

    if (WORD_W > SMP_W) begin : g_pad
        assign slot_word = {{(WORD_W - SMP_W){1'b0}}, smp};
    end else begin : g_trunc
        assign slot_word = smp[WORD_W-1:0];
    end

endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            start,
    input  logic            free_run,
    input  logic            eoc_evt,
    output logic            soc,
    output logic            wr_en,
    output logic            scan_done,
    output logic [CH_W-1:0] ch,
    output logic            buf_sel
);

    scan_state_e state, state_nx;
    logic        last_ch;
    logic        capture;

    assign last_ch = (ch == CH_W'(NUM_CH - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SETTLE;
            ST_SETTLE: state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_WAIT;
            ST_WAIT:   if (eoc_evt)
                           state_nx = (last_ch && !free_run) ? ST_IDLE : ST_SETTLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (soft_rst)
            state_nx = ST_IDLE;
    end

    // outputs
    always_comb begin
        soc       = 1'b0;
        capture   = 1'b0;
        unique case (state)
            ST_IDLE, ST_SETTLE: ;
            ST_LAUNCH: soc = 1'b1;
            ST_WAIT:   capture = eoc_evt && !soft_rst;
            default: ;
        endcase
        wr_en     = capture;
        scan_done = capture && last_ch;
    end

    // channel pointer and buffer half
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch      <= '0;
            buf_sel <= 1'b0;
        end else if (soft_rst) begin
            ch      <= '0;
            buf_sel <= 1'b0;
        end else if (capture) begin
            ch <= last_ch ? '0 : ch + CH_W'(1);
            if (last_ch)
                buf_sel <= ~buf_sel;
        end
    end

    AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> !soc);  // R6
    AST_MUX_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        soc |-> $stable(ch));  // R6
    AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (wr_en && ch == CH_W'(NUM_CH - 1)));  // R5
    AST_BUF_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> (soft_rst || buf_sel != $past(buf_sel)));  // R4
    AST_CH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (soft_rst ||
                   (($past(ch) == CH_W'(NUM_CH - 1)) ? (ch == '0) : (ch == $past(ch) + CH_W'(1)))));  // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !wr_en);  // R10

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int NUM_CH      = 4,
    parameter int SMP_W       = 12,
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = $clog2(2 * NUM_CH * (WORD_W / 8))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              start,
    input  logic              free_run,
    input  logic              eoc_async,
    input  logic [SMP_W-1:0]  smp_data,
    output logic              soc,
    output logic [CH_W-1:0]   mux_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_en,
    output logic              buf_idx,
    output logic              scan_done
);

    logic eoc_evt;

    scan_eoc_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .eoc_async (eoc_async),
        .eoc_evt   (eoc_evt)
    );

    scan_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .start     (start),
        .free_run  (free_run),
        .eoc_evt   (eoc_evt),
        .soc       (soc),
        .wr_en     (wr_en),
        .scan_done (scan_done),
        .ch        (mux_sel),
        .buf_sel   (buf_idx)
    );

    // the slot uses the channel still selected, i.e. the one just converted
    scan_slot_map #(
        .NUM_CH (NUM_CH),
        .SMP_W  (SMP_W),
        .WORD_W (WORD_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) i_map (
        .buf_sel   (buf_idx),
        .ch        (mux_sel),
        .smp       (smp_data),
        .slot_addr (wr_addr),
        .slot_word (wr_data)
    );

endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        start = 1'b0;
    logic        free_run = 1'b0;
    logic        eoc_async = 1'b0;
    logic [11:0] smp_data = '0;
    logic        soc;
    logic [1:0]  mux_sel;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic        wr_en;
    logic        buf_idx;
    logic        scan_done;

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    int soc_cnt = 0;
    int eoc_cnt = 0;
    bit mon_en = 1'b0;
    bit conv_en = 1'b0;
    logic [1:0]  last_ch = '0;
    logic [11:0] last_data = '0;
    logic        prev_soc = 1'b0;
    logic [1:0]  prev_mux = '0;

    always #5 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .start(start),
        .free_run(free_run), .eoc_async(eoc_async), .smp_data(smp_data),
        .soc(soc), .mux_sel(mux_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_en(wr_en), .buf_idx(buf_idx), .scan_done(scan_done)
    );

    function automatic int exp_addr(int b, int ch);
        return (b * 4 + ch) * 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // write monitor
    always @(negedge clk) begin
        if (rst_n && mon_en && wr_en) begin
            int ech;
            int eb;
            ech = wr_cnt % 4;
            eb  = (wr_cnt / 4) % 2;
            chk(int'(last_ch) == ech, "R2", "converted channel order", int'(last_ch), ech);
            chk(int'(wr_addr) == exp_addr(eb, int'(last_ch)), "R3", "slot address",
                int'(wr_addr), exp_addr(eb, int'(last_ch)));
            chk(wr_data == {4'h0, last_data}, "R3", "sample word", int'(wr_data),
                int'({4'h0, last_data}));
            chk(int'(buf_idx) == eb, "R4", "buffer index", int'(buf_idx), eb);
            chk(scan_done == (ech == 3), "R5", "scan done with write", int'(scan_done),
                int'(ech == 3));
            wr_cnt++;
        end
    end

    // start-of-conversion monitor
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (soc) begin
                soc_cnt++;
                chk(!prev_soc, "R6", "soc one cycle", int'(prev_soc), 0);
                chk(mux_sel == prev_mux, "R6", "mux settled before soc", int'(mux_sel),
                    int'(prev_mux));
            end
        end
        prev_soc = soc;
        prev_mux = mux_sel;
    end

    // converter model
    initial begin
        forever begin
            @(negedge clk);
            if (conv_en && soc) begin
                last_ch = mux_sel;
                repeat ($urandom_range(1, 10)) @(negedge clk);
                last_data = 12'($urandom);
                smp_data  = last_data;
                eoc_async = 1'b1;
                eoc_cnt++;
                repeat (2) @(negedge clk);
                eoc_async = 1'b0;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_writes(input int target);
        int lim;
        lim = 0;
        while (wr_cnt < target && lim < 5000) begin
            @(negedge clk);
            lim++;
        end
        chk(wr_cnt >= target, "R8", "writes reached", wr_cnt, target);
    endtask

    task automatic manual_conv(input logic [11:0] d);
        do @(negedge clk); while (!soc);
        last_ch = mux_sel;
        last_data = d;
        smp_data = d;
        repeat (2) @(negedge clk);
        eoc_async = 1'b1;
        repeat (2) @(negedge clk);
        eoc_async = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int snap_w;
        int snap_s;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!soc && !wr_en && !scan_done, "R11", "strobes low after reset",
            int'({soc, wr_en, scan_done}), 0);
        chk(mux_sel == 2'd0, "R11", "mux after reset", int'(mux_sel), 0);
        chk(buf_idx == 1'b0, "R11", "buffer after reset", int'(buf_idx), 0);
        mon_en = 1'b1;

        // R8 free run with random conversion times, many passes
        conv_en = 1'b1;
        free_run = 1'b1;
        pulse_start();
        wait_writes(6);
        pulse_start();                      // R8 start while busy: no effect
        wait_writes(33);
        @(negedge clk);
        free_run = 1'b0;
        wait_writes(36);
        repeat (40) @(negedge clk);
        chk(wr_cnt == 36, "R7", "stopped at end of pass", wr_cnt, 36);
        chk(eoc_cnt == wr_cnt, "R1", "one write per strobe", wr_cnt, eoc_cnt);
        chk(soc_cnt == 36, "R2", "one soc per conversion", soc_cnt, 36);
        chk(mux_sel == 2'd0, "R7", "mux back to 0", int'(mux_sel), 0);

        // R7 one-shot pass with a start pulse in the middle
        pulse_start();
        wait_writes(38);
        pulse_start();
        wait_writes(40);
        snap_s = soc_cnt;
        repeat (60) @(negedge clk);
        chk(wr_cnt == 40, "R7", "one-shot single pass", wr_cnt, 40);
        chk(soc_cnt == snap_s, "R7", "no soc after one-shot", soc_cnt, snap_s);
        chk(eoc_cnt == wr_cnt, "R1", "write count equals strobes", wr_cnt, eoc_cnt);
        chk(buf_idx == 1'b0, "R4", "buffer after even passes", int'(buf_idx), 0);

        // R10 strobe while idle
        conv_en = 1'b0;
        snap_w = wr_cnt;
        @(negedge clk);
        eoc_async = 1'b1;
        repeat (3) @(negedge clk);
        eoc_async = 1'b0;
        repeat (10) @(negedge clk);
        chk(wr_cnt == snap_w, "R10", "no write from idle strobe", wr_cnt, snap_w);

        // R9 soft reset with a strobe inside the synchronizer, buffer 1 half
        free_run = 1'b1;
        pulse_start();
        manual_conv(12'hA5C);
        manual_conv(12'h3F0);
        manual_conv(12'h00F);
        manual_conv(12'hFFF);               // pass ends, buffer now 1
        do @(negedge clk); while (!soc);
        last_ch = mux_sel;
        repeat (2) @(negedge clk);
        snap_w = wr_cnt;
        eoc_async = 1'b1;
        @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        @(negedge clk);
        eoc_async = 1'b0;
        snap_s = soc_cnt;
        repeat (12) @(negedge clk);
        chk(wr_cnt == snap_w, "R9", "in-flight strobe dropped", wr_cnt, snap_w);
        chk(mux_sel == 2'd0, "R9", "mux cleared", int'(mux_sel), 0);
        chk(buf_idx == 1'b0, "R9", "buffer cleared", int'(buf_idx), 0);
        chk(soc_cnt == snap_s, "R9", "idle after soft reset", soc_cnt, snap_s);

        // restart from slot 0 of buffer 0
        wr_cnt = 0;
        eoc_cnt = 0;
        free_run = 1'b0;
        conv_en = 1'b1;
        pulse_start();
        wait_writes(4);
        repeat (30) @(negedge clk);
        chk(wr_cnt == 4, "R7", "pass after soft reset", wr_cnt, 4);
        chk(buf_idx == 1'b1, "R4", "buffer toggled after pass", int'(buf_idx), 1);
        summary();
    end

endmodule